// File: doc/BRIEF.md
# Event Notification Descriptor Processor

This block takes a notification trigger that names a descriptor by block number and index and carries a 31-bit event value. It fetches the eight-word descriptor from an external descriptor table and runs a fixed series of checks on it. The checks gate two separate side effects. The first is an optional append of the event value to the descriptor's circular event queue, followed by a write-back of the queue state word. The second is an optional forward of a notification to the virtual target that the descriptor names. Every trigger ends in exactly one outcome: a notify request or a drop with a reason code.

The block is a six-state machine. Its states are IDLE, FETCH, CHECK, ENQUEUE, WRITEBACK and NOTIFY. The transitions are:

- IDLE to FETCH when a trigger is accepted.
- FETCH to CHECK on a good table answer, or FETCH to NOTIFY on a lookup error.
- CHECK to NOTIFY when the descriptor is not valid or when no enqueue is requested. CHECK to ENQUEUE when enqueue is requested.
- ENQUEUE to WRITEBACK.
- WRITEBACK to NOTIFY.
- NOTIFY to IDLE. NOTIFY is the one cycle in which the outcome is presented.

Descriptor words use MSB-first bit numbering, so field bit n of a word is hardware bit 31-n. Word k of the table answer sits at `tbl_rd_data[32*k +: 32]`.

Top module: `endp_top`

## Requirements
- R1: After reset, `trig_ready` is 1 and every request and outcome output is 0. `trig_ready` is 1 only in IDLE. After a trigger is accepted, `trig_ready` stays 0 until the cycle after the outcome.
- R2: In FETCH, `tbl_rd_req` stays high until `tbl_rd_ack`. While it is high, it presents the accepted block number and index.
- R3: If the table answer has `tbl_rd_err`=1, the trigger is dropped with `drop_code`=1. Nothing is pushed to the queue and nothing is written back.
- R4: If the valid flag (word 0, hardware bit 31) is 0, the trigger is dropped with `drop_code`=2. Nothing is pushed and nothing is written back.
- R5: If the enqueue flag (word 0, hardware bit 30) is 1, the block raises `q_push` for exactly one cycle. In that cycle, `q_slot` is the queue index (word 1, bits 21:0). `q_entry` is the generation bit (word 1, bit 22) followed by the 31-bit event value.
- R6: The cycle after the push, `wb_en` pulses with a new word 1. Its index is (index+1) modulo 2^(qsize+QBASE_LOG2), where qsize is word 0 bits 19:16. Word 1 bits 31:23 are returned unchanged. No write-back occurs without a push.
- R7: When the new index wraps to 0, the generation bit in the written-back word is inverted. Otherwise it is kept.
- R8: The format flag is word 6 bit 23. The priority is word 7 bits 23:16. When the format is 0 and the priority is 0xFF, the trigger is dropped with `drop_code`=3, after any enqueue and write-back have finished.
- R9: Otherwise, if the unconditional-notify flag (word 0, bit 29) is 0, the trigger is dropped with `drop_code`=4.
- R10: Otherwise `notify_valid` pulses. The request carries `notify_fmt` (the format flag), `notify_blk` (word 6 bits 22:19) and `notify_idx` (word 6 bits 18:0). It also carries `notify_prio`, which is the word 7 priority for format 0 and 0 for format 1.
- R11: Each accepted trigger produces exactly one one-cycle outcome, either `notify_valid` or `drop_valid`, never both. The block returns to IDLE the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger present |
| trig_ready | output | 1 | Block is idle and takes a trigger |
| trig_blk | input | BLK_W | Descriptor block number |
| trig_idx | input | IDX_W | Descriptor index |
| trig_data | input | 31 | Event value |
| tbl_rd_req | output | 1 | Descriptor fetch request |
| tbl_rd_blk | output | BLK_W | Fetch block number |
| tbl_rd_idx | output | IDX_W | Fetch index |
| tbl_rd_ack | input | 1 | Fetch answer present |
| tbl_rd_err | input | 1 | Lookup failed |
| tbl_rd_data | input | 256 | Eight descriptor words |
| q_push | output | 1 | Append one queue entry |
| q_slot | output | 22 | Queue slot being written |
| q_entry | output | 32 | Generation bit and event value |
| wb_en | output | 1 | Write back descriptor word 1 |
| wb_blk | output | BLK_W | Write-back block number |
| wb_idx | output | IDX_W | Write-back index |
| wb_word1 | output | 32 | New descriptor word 1 |
| notify_valid | output | 1 | Forward a notification |
| notify_fmt | output | 1 | Descriptor format flag |
| notify_blk | output | 4 | Target block |
| notify_idx | output | 19 | Target index |
| notify_prio | output | 8 | Target priority |
| drop_valid | output | 1 | Trigger dropped |
| drop_code | output | 3 | Drop reason (1 lookup, 2 invalid, 3 masked, 4 not unconditional) |

## Verification
The bench builds the block with QBASE_LOG2=2 and IDX_W=8. With those values, a qsize of 0 gives a four-entry queue, so the index wrap and the generation flip (R7) occur after four enqueues to the same descriptor. A qsize of 1 gives eight entries, which exercises the size field in the modulo (R6). The table model varies its answer latency per index, which keeps FETCH held for zero to two extra cycles. It fails lookups for any block number other than 1.

// File: rtl/endp_pkg.sv
package endp_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 8;
    localparam int DESC_W     = WORD_W * DESC_WORDS;
    localparam int EVT_W      = 31;
    localparam int QIDX_W     = 22;
    localparam int TBLK_W     = 4;
    localparam int TIDX_W     = 19;
    localparam int PRIO_W     = 8;

    // hardware bit = WORD_W-1-n for MSB-first field bit n
    localparam int B_VALID   = WORD_W - 1 - 0;
    localparam int B_ENQ     = WORD_W - 1 - 1;
    localparam int B_UNCOND  = WORD_W - 1 - 2;
    localparam int B_QSZ_HI  = WORD_W - 1 - 12;
    localparam int B_GEN     = WORD_W - 1 - 9;
    localparam int B_FMT     = WORD_W - 1 - 8;
    localparam int B_TBLK_HI = WORD_W - 1 - 9;
    localparam int B_PRIO_HI = WORD_W - 1 - 8;

    localparam logic [PRIO_W-1:0] PRIO_OFF = 8'hFF;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CHECK, S_ENQUEUE, S_WRITEBACK, S_NOTIFY
    } state_t;

    typedef enum logic [2:0] {
        DROP_NONE     = 3'd0,
        DROP_LOOKUP   = 3'd1,
        DROP_INVALID  = 3'd2,
        DROP_MASKED   = 3'd3,
        DROP_NOUNCOND = 3'd4
    } drop_t;

    typedef struct packed {
        logic              valid;
        logic              enq;
        logic              uncond;
        logic [3:0]        qsize;
        logic              gen;
        logic [QIDX_W-1:0] qidx;
        logic [WORD_W-1:0] w1;
        logic              fmt;
        logic [TBLK_W-1:0] tblk;
        logic [TIDX_W-1:0] tidx;
        logic [PRIO_W-1:0] prio;
    } desc_t;
endpackage

// File: rtl/endp_decode.sv
module endp_decode
    import endp_pkg::*;
(
    input  logic [DESC_W-1:0] raw,
    output desc_t             d
);
    logic [WORD_W-1:0] w [DESC_WORDS];

    for (genvar k = 0; k < DESC_WORDS; k++) begin : g_word
        assign w[k] = raw[k*WORD_W +: WORD_W];
    end

    always_comb begin
        d.valid  = w[0][B_VALID];
        d.enq    = w[0][B_ENQ];
        d.uncond = w[0][B_UNCOND];
        d.qsize  = w[0][B_QSZ_HI -: 4];
        d.gen    = w[1][B_GEN];
        d.qidx   = w[1][QIDX_W-1:0];
        d.w1     = w[1];
        d.fmt    = w[6][B_FMT];
        d.tblk   = w[6][B_TBLK_HI -: TBLK_W];
        d.tidx   = w[6][TIDX_W-1:0];
        d.prio   = w[7][B_PRIO_HI -: PRIO_W];
    end
endmodule

// File: rtl/endp_qstep.sv
module endp_qstep
    import endp_pkg::*;
#(
    parameter int QBASE_LOG2 = 10
) (
    input  logic [3:0]        qsize,
    input  logic [QIDX_W-1:0] cur_idx,
    input  logic              cur_gen,
    output logic [QIDX_W-1:0] nxt_idx,
    output logic              nxt_gen
);
    localparam int LG_W = 7;

    logic [LG_W-1:0]   lg;
    logic [QIDX_W-1:0] mask;

    assign lg = LG_W'(qsize) + LG_W'(QBASE_LOG2);

    for (genvar b = 0; b < QIDX_W; b++) begin : g_mask
        assign mask[b] = (LG_W'(b) < lg);
    end

    always_comb begin
        nxt_idx = (cur_idx + 1'b1) & mask;
        nxt_gen = cur_gen ^ (nxt_idx == '0);
    end
endmodule

// File: rtl/endp_top.sv
module endp_top
    import endp_pkg::*;
#(
    parameter int BLK_W      = 4,
    parameter int IDX_W      = 24,
    parameter int QBASE_LOG2 = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   trig_valid,
    output logic                   trig_ready,
    input  logic [BLK_W-1:0]       trig_blk,
    input  logic [IDX_W-1:0]       trig_idx,
    input  logic [30:0]            trig_data,
    output logic                   tbl_rd_req,
    output logic [BLK_W-1:0]       tbl_rd_blk,
    output logic [IDX_W-1:0]       tbl_rd_idx,
    input  logic                   tbl_rd_ack,
    input  logic                   tbl_rd_err,
    input  logic [255:0]           tbl_rd_data,
    output logic                   q_push,
    output logic [21:0]            q_slot,
    output logic [31:0]            q_entry,
    output logic                   wb_en,
    output logic [BLK_W-1:0]       wb_blk,
    output logic [IDX_W-1:0]       wb_idx,
    output logic [31:0]            wb_word1,
    output logic                   notify_valid,
    output logic                   notify_fmt,
    output logic [3:0]             notify_blk,
    output logic [18:0]            notify_idx,
    output logic [7:0]             notify_prio,
    output logic                   drop_valid,
    output logic [2:0]             drop_code
);
    state_t             state, nxt_state;
    logic [BLK_W-1:0]   blk_q;
    logic [IDX_W-1:0]   idx_q;
    logic [EVT_W-1:0]   data_q;
    logic [DESC_W-1:0]  raw_q;
    logic [WORD_W-1:0]  w1n_q;
    drop_t              res_q;
    drop_t              fin;
    desc_t              d;
    logic [QIDX_W-1:0]  nidx;
    logic               ngen;

    endp_decode u_dec (
        .raw (raw_q),
        .d   (d)
    );

    endp_qstep #(.QBASE_LOG2(QBASE_LOG2)) u_qstep (
        .qsize   (d.qsize),
        .cur_idx (d.qidx),
        .cur_gen (d.gen),
        .nxt_idx (nidx),
        .nxt_gen (ngen)
    );

    // next state
    always_comb begin
        nxt_state = state;
        unique case (state)
            S_IDLE:      if (trig_valid) nxt_state = S_FETCH;
            S_FETCH:     if (tbl_rd_ack) nxt_state = tbl_rd_err ? S_NOTIFY : S_CHECK;
            S_CHECK:     nxt_state = (d.valid && d.enq) ? S_ENQUEUE : S_NOTIFY;
            S_ENQUEUE:   nxt_state = S_WRITEBACK;
            S_WRITEBACK: nxt_state = S_NOTIFY;
            S_NOTIFY:    nxt_state = S_IDLE;
            default:     nxt_state = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt_state;
    end

    // captured trigger, descriptor and early verdicts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q  <= '0;
            idx_q  <= '0;
            data_q <= '0;
            raw_q  <= '0;
            w1n_q  <= '0;
            res_q  <= DROP_NONE;
        end else begin
            if (state == S_IDLE && trig_valid) begin
                blk_q  <= trig_blk;
                idx_q  <= trig_idx;
                data_q <= trig_data;
                res_q  <= DROP_NONE;
            end
            if (state == S_FETCH && tbl_rd_ack) begin
                if (tbl_rd_err) res_q <= DROP_LOOKUP;
                else            raw_q <= tbl_rd_data;
            end
            if (state == S_CHECK && !d.valid) res_q <= DROP_INVALID;
            if (state == S_ENQUEUE)
                w1n_q <= {d.w1[WORD_W-1:B_GEN+1], ngen, nidx};
        end
    end

    // final verdict: early drop wins, then mask, then notify condition
    always_comb begin
        if (res_q != DROP_NONE)                 fin = res_q;
        else if (!d.fmt && d.prio == PRIO_OFF)  fin = DROP_MASKED;
        else if (!d.uncond)                     fin = DROP_NOUNCOND;
        else                                    fin = DROP_NONE;
    end

    // outputs
    always_comb begin
        trig_ready   = (state == S_IDLE);
        tbl_rd_req   = (state == S_FETCH);
        tbl_rd_blk   = blk_q;
        tbl_rd_idx   = idx_q;
        q_push       = (state == S_ENQUEUE);
        q_slot       = d.qidx;
        q_entry      = {d.gen, data_q};
        wb_en        = (state == S_WRITEBACK);
        wb_blk       = blk_q;
        wb_idx       = idx_q;
        wb_word1     = w1n_q;
        notify_valid = (state == S_NOTIFY) && (fin == DROP_NONE);
        drop_valid   = (state == S_NOTIFY) && (fin != DROP_NONE);
        drop_code    = drop_valid ? fin : DROP_NONE;
        notify_fmt   = d.fmt;
        notify_blk   = d.tblk;
        notify_idx   = d.tidx;
        notify_prio  = d.fmt ? '0 : d.prio;
    end
endmodule

// File: rtl/endp_chk.sv
module endp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_valid,
    input logic       trig_ready,
    input logic       tbl_rd_req,
    input logic       tbl_rd_ack,
    input logic       tbl_rd_err,
    input logic       q_push,
    input logic       wb_en,
    input logic       notify_valid,
    input logic       notify_fmt,
    input logic [7:0] notify_prio,
    input logic       drop_valid,
    input logic [2:0] drop_code
);
    // R1
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid && trig_ready |=> !trig_ready);
    // R2
    fetch_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_req && !tbl_rd_ack |=> tbl_rd_req);
    // R3
    lookup_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_req && tbl_rd_ack && tbl_rd_err |=> drop_valid && drop_code == 3'd1);
    // R6
    wb_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |=> wb_en);
    // R8
    masked_not_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid && !notify_fmt |-> notify_prio != 8'hFF);
    // R11
    single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(notify_valid && drop_valid));
    // R11
    idle_after_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid || drop_valid |=> trig_ready);
endmodule

bind endp_top endp_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_valid   (trig_valid),
    .trig_ready   (trig_ready),
    .tbl_rd_req   (tbl_rd_req),
    .tbl_rd_ack   (tbl_rd_ack),
    .tbl_rd_err   (tbl_rd_err),
    .q_push       (q_push),
    .wb_en        (wb_en),
    .notify_valid (notify_valid),
    .notify_fmt   (notify_fmt),
    .notify_prio  (notify_prio),
    .drop_valid   (drop_valid),
    .drop_code    (drop_code)
);

// File: tb/sim_endp_top.sv
module sim_endp_top;
    localparam int CLK_PERIOD = 10;
    localparam int BLK_W = 4;
    localparam int IDX_W = 8;
    localparam int QB    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_valid = 1'b0;
    logic trig_ready;
    logic [BLK_W-1:0] trig_blk = '0;
    logic [IDX_W-1:0] trig_idx = '0;
    logic [30:0] trig_data = '0;
    logic tbl_rd_req;
    logic [BLK_W-1:0] tbl_rd_blk;
    logic [IDX_W-1:0] tbl_rd_idx;
    logic tbl_rd_ack = 1'b0;
    logic tbl_rd_err = 1'b0;
    logic [255:0] tbl_rd_data = '0;
    logic q_push;
    logic [21:0] q_slot;
    logic [31:0] q_entry;
    logic wb_en;
    logic [BLK_W-1:0] wb_blk;
    logic [IDX_W-1:0] wb_idx;
    logic [31:0] wb_word1;
    logic notify_valid, notify_fmt, drop_valid;
    logic [3:0] notify_blk;
    logic [18:0] notify_idx;
    logic [7:0] notify_prio;
    logic [2:0] drop_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    endp_top #(.BLK_W(BLK_W), .IDX_W(IDX_W), .QBASE_LOG2(QB)) u0 (.*);

    typedef struct {
        int          kind;
        logic [63:0] val;
        string       req;
    } item_t;

    item_t exp_q[$];
    logic [255:0] tbl [16];
    logic [BLK_W-1:0] cur_blk = '0;
    logic [IDX_W-1:0] cur_idx = '0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [255:0] mk(input bit v, input bit enq, input bit unc,
            input logic [3:0] qs, input bit gen, input logic [21:0] qi, input logic [8:0] w1hi,
            input bit fmt, input logic [3:0] tb, input logic [18:0] ti, input logic [7:0] pr);
        logic [255:0] r;
        r = {8{32'h5A5A_0F0F}};
        r[31:0]    = {v, enq, unc, 9'h0A5, qs, 16'h1234};
        r[63:32]   = {w1hi, gen, qi};
        r[223:192] = {8'hC3, fmt, tb, ti};
        r[255:224] = {8'h81, pr, 16'h7E7E};
        return r;
    endfunction

    function automatic item_t it(input int k, input logic [63:0] v, input string r);
        item_t x;
        x.kind = k; x.val = v; x.req = r;
        return x;
    endfunction

    // driver: predicts, pushes expectations, fires one trigger, waits for drain
    task automatic send(input logic [3:0] b, input logic [7:0] i, input logic [30:0] dat);
        logic [255:0] w;
        logic [31:0] w0, w1, w6, w7;
        logic [21:0] ni, mask;
        bit ng;
        int lg;
        if (b != 4'd1 || i >= 8'd16) begin
            exp_q.push_back(it(4, 64'd1, "R3 lookup drop"));
        end else begin
            w = tbl[i[3:0]];
            w0 = w[31:0]; w1 = w[63:32]; w6 = w[223:192]; w7 = w[255:224];
            if (!w0[31]) begin
                exp_q.push_back(it(4, 64'd2, "R4 invalid drop"));
            end else begin
                if (w0[30]) begin
                    exp_q.push_back(it(1, {10'd0, w1[21:0], w1[22], dat}, "R5 push"));
                    lg = int'(w0[19:16]) + QB;
                    mask = (lg >= 22) ? '1 : 22'((64'd1 << lg) - 1);
                    ni = (w1[21:0] + 22'd1) & mask;
                    ng = w1[22] ^ (ni == 22'd0);
                    exp_q.push_back(it(2, {32'd0, w1[31:23], ng, ni},
                        (ni == 0) ? "R7 wrap write-back" : "R6 write-back"));
                end
                if (!w6[23] && w7[23:16] == 8'hFF)
                    exp_q.push_back(it(4, 64'd3, "R8 masked drop"));
                else if (!w0[29])
                    exp_q.push_back(it(4, 64'd4, "R9 no-uncond drop"));
                else
                    exp_q.push_back(it(3, {32'd0, w6[23], w6[22:19], w6[18:0],
                        (w6[23] ? 8'd0 : w7[23:16])}, "R10 notify"));
            end
        end
        @(negedge clk);
        while (!trig_ready) @(negedge clk);
        cur_blk = b; cur_idx = i;
        trig_valid = 1'b1; trig_blk = b; trig_idx = i; trig_data = dat;
        @(negedge clk);
        trig_valid = 1'b0;
        chk(trig_ready == 1'b0, "R1 busy after accept", 64'(trig_ready), 64'd0);
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(trig_ready == 1'b1, "R11 back to idle", 64'(trig_ready), 64'd1);
    endtask

    // table model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tbl_rd_req && !tbl_rd_ack) begin
                chk(tbl_rd_blk == cur_blk && tbl_rd_idx == cur_idx, "R2 fetch address",
                    64'({tbl_rd_blk, tbl_rd_idx}), 64'({cur_blk, cur_idx}));
                repeat (int'(cur_idx) % 3) @(negedge clk);
                tbl_rd_err  = !(cur_blk == 4'd1 && cur_idx < 8'd16);
                tbl_rd_data = tbl_rd_err ? {8{32'hDEAD_BEEF}} : tbl[cur_idx[3:0]];
                tbl_rd_ack  = 1'b1;
                @(negedge clk);
                tbl_rd_ack  = 1'b0;
                tbl_rd_err  = 1'b0;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (q_push || wb_en || notify_valid || drop_valid)) begin
                item_t a, e;
                if (q_push)            a = it(1, {10'd0, q_slot, q_entry}, "");
                else if (wb_en)        a = it(2, {32'd0, wb_word1}, "");
                else if (notify_valid) a = it(3, {32'd0, notify_fmt, notify_blk, notify_idx, notify_prio}, "");
                else                   a = it(4, {61'd0, drop_code}, "");
                if (wb_en) tbl[wb_idx[3:0]][63:32] = wb_word1;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected output", {32'(a.kind), a.val[31:0]}, 64'd0);
                end else begin
                    e = exp_q.pop_front();
                    chk(a.kind == e.kind && a.val == e.val, e.req,
                        {32'(a.kind), a.val[31:0]}, {32'(e.kind), e.val[31:0]});
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 16; k++) tbl[k] = '0;
        tbl[0] = mk(1, 1, 1, 4'd0, 0, 22'd0, 9'h155, 0, 4'h9, 19'h12345, 8'd3);
        tbl[1] = mk(0, 1, 1, 4'd0, 0, 22'd0, 9'h000, 0, 4'h1, 19'h00001, 8'd1);
        tbl[2] = mk(1, 1, 1, 4'd0, 1, 22'd2, 9'h0F0, 0, 4'h2, 19'h00002, 8'hFF);
        tbl[3] = mk(1, 0, 1, 4'd0, 0, 22'd0, 9'h000, 0, 4'h3, 19'h00003, 8'hFF);
        tbl[4] = mk(1, 0, 0, 4'd0, 0, 22'd0, 9'h000, 0, 4'h4, 19'h00004, 8'd5);
        tbl[5] = mk(1, 0, 1, 4'd0, 0, 22'd0, 9'h000, 1, 4'hA, 19'h7FFFF, 8'hFF);
        tbl[6] = mk(1, 1, 1, 4'd1, 1, 22'd5, 9'h1AB, 0, 4'hF, 19'h0ABCD, 8'd7);
        tbl[7] = mk(1, 1, 0, 4'd0, 0, 22'd3, 9'h000, 0, 4'h7, 19'h00007, 8'd0);

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(trig_ready == 1'b1, "R1 reset ready", 64'(trig_ready), 64'd1);
        chk({tbl_rd_req, q_push, wb_en, notify_valid, drop_valid} == 5'd0, "R1 reset outputs",
            64'({tbl_rd_req, q_push, wb_en, notify_valid, drop_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5/R6: four enqueues walk the four-entry queue, the fourth wraps (R7)
        for (int n = 0; n < 4; n++) send(4'd1, 8'd0, 31'h1000_0000 + 31'(n));
        // R5: after wrap the pushed entry carries generation 1
        send(4'd1, 8'd0, 31'h7FFF_FFFF);
        send(4'd1, 8'd1, 31'h11);       // R4
        send(4'd2, 8'd0, 31'h22);       // R3 bad block
        send(4'd1, 8'd40, 31'h23);      // R3 bad index
        send(4'd1, 8'd2, 31'h33);       // R8 enqueue then masked
        send(4'd1, 8'd3, 31'h44);       // R8 masked, no enqueue
        send(4'd1, 8'd4, 31'h55);       // R9
        send(4'd1, 8'd5, 31'h66);       // R10 format 1, priority 0
        send(4'd1, 8'd6, 31'h77);       // R6 eight-entry queue, upper bits kept
        send(4'd1, 8'd6, 31'h78);
        send(4'd1, 8'd6, 31'h79);       // R7 wrap in eight-entry queue
        send(4'd1, 8'd7, 31'h0AA);      // R9 after enqueue, wrap R7
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule